// File: doc/BRIEF.md
# Quadrature Clock Phase Generator

This block turns a fast input clock into four square waves spaced a quarter of an output period apart: an in-phase output, a quadrature output and the complement of each. It feeds mixers that need 0, 90, 180 and 270 degree drive. In its default arrangement the input clock runs at twice the wanted output rate. Two flip-flops form a divide-by-two loop. The first captures the inverse of the second on the rising input edge. The second copies the first on the falling input edge. The second output therefore trails the first by half an input period, which is a quarter of the output period.

For lower output rates a second arrangement can be selected. In it, a twisted ring of M stages, all clocked on the rising input edge, divides the input by 2M. The in-phase output is taken from the first stage and the quadrature output from the stage M/2 positions down the ring. This needs M to be even and between 2 and the configured maximum. Any other length is refused: the error flag is raised and all four outputs are forced low.

The enable input acts as a synchronous clear. While it is low, or while a core is not the selected one, that core returns to all-zero. Each fresh start, or each change of arrangement, therefore begins from the same phase. No data stream passes through the block. Every pin is a plain control or clock-derived level, so no valid/ready handshake applies.

Top module: `qdiv_quad_gen`

## Requirements
- R1: While `rst_n` is low, `out_i`, `out_q` and `cfg_err` are 0 and `out_ix`, `out_qx` are 1, whatever `en` is. After release with `en` low they stay so.
- R2: With `ring_mode` = 0 (divide-by-two) and `en` high, `out_i` inverts on every rising edge of `clk2x`, so its period is two input cycles.
- R3: In divide-by-two, `out_q` takes the value of `out_i` on each falling edge of `clk2x`. From a cleared state the (I,Q) pairs run 00, 10, 11, 01 and repeat, with I moving first.
- R4: Whenever `cfg_err` is 0, `out_ix` equals the inverse of `out_i` and `out_qx` equals the inverse of `out_q`.
- R5: A rising edge with `en` low clears the I flop, and a falling edge with `en` low clears the Q flop. Re-enabling restarts the sequence from 00 with I moving first.
- R6: With `ring_mode` = 1 and a valid even `ring_len` M (2, 4, 6 or 8 by default), counting the enabled rising edges from a cleared ring as r = 1, 2, ..., `out_i` is 1 exactly when (r-1) mod 2M < M. The output period is 2M input cycles.
- R7: In ring mode, `out_q` equals the value `out_i` had M/2 rising edges earlier (0 before that), and `out_i` and `out_q` never change on the same edge.
- R8: With `ring_mode` = 1 and `ring_len` odd, below 2 or above the maximum, `cfg_err` is 1 at once. `out_i`, `out_q`, `out_ix` and `out_qx` are all 0, and the ring is cleared on the next rising edge.
- R9: In divide-by-two, `ring_len` has no effect: `cfg_err` stays 0 and the outputs follow R2 and R3 for any value, odd values included.
- R10: The core that is not selected is held clear. Switching `ring_mode` while `en` is high therefore starts the newly selected core from 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Input clock, twice the output rate in divide-by-two arrangement |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the cores synchronously |
| ring_mode | input | 1 | 0 = flip-flop pair divide-by-two, 1 = twisted ring divide-by-2M |
| ring_len | input | LEN_W (4) | Ring length M used in ring arrangement |
| out_i | output | 1 | In-phase output (0 degrees) |
| out_q | output | 1 | Quadrature output (90 degrees) |
| out_ix | output | 1 | Inverted in-phase output (180 degrees) |
| out_qx | output | 1 | Inverted quadrature output (270 degrees) |
| cfg_err | output | 1 | Ring length refused in ring arrangement |

## Verification
The properties assume that `en`, `ring_mode` and `ring_len` change only between a falling edge and the next rising edge of `clk2x`. The rising edge that updates I and the falling edge that updates Q thus see the same settings. The bench changes inputs only a quarter period after each falling edge, and compares outputs twice per input cycle, once between the rising and falling edge and once after the falling edge. It sweeps every value of `ring_len` in both arrangements, drops and raises `en`, and switches arrangement while running.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;

  // Default upper bound on the twisted ring length.
  localparam int unsigned QD_MAX_STAGES_DEF = 8;

  // Which divider core drives the outputs.
  typedef enum logic {
    QD_MODE_PAIR = 1'b0,
    QD_MODE_RING = 1'b1
  } qd_mode_e;

  // In-phase and quadrature levels produced by one core.
  typedef struct packed {
    logic i;
    logic q;
  } qd_pair_t;

endpackage

// File: rtl/qdiv_flop_pair.sv
// Divide-by-two loop: the I flop loads the inverse of Q on the rising edge,
// the Q flop copies I on the falling edge, so Q trails I by half an input period.
module qdiv_flop_pair
  import qdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  output qd_pair_t pair
);

  logic i_r;
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_r <= 1'b0;
    end else if (!run) begin
      i_r <= 1'b0;
    end else begin
      i_r <= ~q_r;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (!run) begin
      q_r <= 1'b0;
    end else begin
      q_r <= i_r;
    end
  end

  assign pair.i = i_r;
  assign pair.q = q_r;

endmodule

// File: rtl/qdiv_twisted_ring.sv
// Twisted ring of up to MAX_STAGES flops on the rising edge; the active length
// is chosen at run time and the quadrature tap sits half way along it.
module qdiv_twisted_ring
  import qdiv_pkg::*;
#(
  parameter int unsigned MAX_STAGES = QD_MAX_STAGES_DEF,
  parameter int unsigned LEN_W      = $clog2(MAX_STAGES + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output qd_pair_t         pair
);

  localparam int unsigned IDX_W = (MAX_STAGES > 2) ? $clog2(MAX_STAGES) : 1;

  logic [MAX_STAGES-1:0] ring;
  logic [MAX_STAGES-1:0] ring_nxt;
  logic [IDX_W-1:0]      tail_idx;
  logic [IDX_W-1:0]      tap_idx;
  logic                  tail;

  // Last active stage closes the loop inverted; the tap is M/2 stages down.
  assign tail_idx = IDX_W'(len - 1'b1);
  assign tap_idx  = IDX_W'(len >> 1);
  assign tail     = ring[tail_idx];

  generate
    for (genvar k = 0; k < MAX_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign ring_nxt[k] = ~tail;
      end else begin : g_body
        assign ring_nxt[k] = ring[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring <= '0;
    end else if (!run) begin
      ring <= '0;
    end else begin
      ring <= ring_nxt;
    end
  end

  assign pair.i = ring[0];
  assign pair.q = ring[tap_idx];

endmodule

// File: rtl/qdiv_cfg_check.sv
// Decides whether the requested ring length can give quadrature.
module qdiv_cfg_check
  import qdiv_pkg::*;
#(
  parameter int unsigned MAX_STAGES = QD_MAX_STAGES_DEF,
  parameter int unsigned LEN_W      = $clog2(MAX_STAGES + 1)
)(
  input  qd_mode_e         mode,
  input  logic [LEN_W-1:0] len,
  output logic             ring_ok,
  output logic             err
);

  always_comb begin
    ring_ok = (len >= LEN_W'(2)) && (len <= LEN_W'(MAX_STAGES)) && !len[0];
    err     = (mode == QD_MODE_RING) && !ring_ok;
  end

endmodule

// File: rtl/qdiv_out_sel.sv
// Picks the active core and forms the four phases; a refused setting forces all low.
module qdiv_out_sel
  import qdiv_pkg::*;
(
  input  qd_mode_e mode,
  input  logic     err,
  input  qd_pair_t pair_flop,
  input  qd_pair_t pair_ring,
  output logic     ph0,
  output logic     ph90,
  output logic     ph180,
  output logic     ph270
);

  qd_pair_t sel;

  always_comb begin
    sel = (mode == QD_MODE_RING) ? pair_ring : pair_flop;
    if (err) begin
      ph0   = 1'b0;
      ph90  = 1'b0;
      ph180 = 1'b0;
      ph270 = 1'b0;
    end else begin
      ph0   = sel.i;
      ph90  = sel.q;
      ph180 = ~sel.i;
      ph270 = ~sel.q;
    end
  end

endmodule

// File: rtl/qdiv_quad_gen.sv
module qdiv_quad_gen
  import qdiv_pkg::*;
#(
  parameter int unsigned MAX_STAGES = QD_MAX_STAGES_DEF,
  parameter int unsigned LEN_W      = $clog2(MAX_STAGES + 1)
)(
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ring_mode,
  input  logic [LEN_W-1:0] ring_len,
  output logic             out_i,
  output logic             out_q,
  output logic             out_ix,
  output logic             out_qx,
  output logic             cfg_err
);

  qd_mode_e mode;
  logic     ring_ok;
  logic     run_flop;
  logic     run_ring;
  qd_pair_t pair_flop;
  qd_pair_t pair_ring;

  assign mode = qd_mode_e'(ring_mode);

  qdiv_cfg_check #(
    .MAX_STAGES (MAX_STAGES),
    .LEN_W      (LEN_W)
  ) u_cfg (
    .mode    (mode),
    .len     (ring_len),
    .ring_ok (ring_ok),
    .err     (cfg_err)
  );

  // The idle core is held clear so a switch always starts from 00.
  assign run_flop = en && (mode == QD_MODE_PAIR);
  assign run_ring = en && (mode == QD_MODE_RING) && ring_ok;

  qdiv_flop_pair u_pair (
    .clk   (clk2x),
    .rst_n (rst_n),
    .run   (run_flop),
    .pair  (pair_flop)
  );

  qdiv_twisted_ring #(
    .MAX_STAGES (MAX_STAGES),
    .LEN_W      (LEN_W)
  ) u_ring (
    .clk   (clk2x),
    .rst_n (rst_n),
    .run   (run_ring),
    .len   (ring_len),
    .pair  (pair_ring)
  );

  qdiv_out_sel u_sel (
    .mode      (mode),
    .err       (cfg_err),
    .pair_flop (pair_flop),
    .pair_ring (pair_ring),
    .ph0       (out_i),
    .ph90      (out_q),
    .ph180     (out_ix),
    .ph270     (out_qx)
  );

endmodule

// File: rtl/qdiv_quad_gen_chk.sv
module qdiv_quad_gen_chk #(
  parameter int unsigned MAX_STAGES = 8,
  parameter int unsigned LEN_W      = $clog2(MAX_STAGES + 1)
)(
  input logic             clk2x,
  input logic             rst_n,
  input logic             en,
  input logic             ring_mode,
  input logic [LEN_W-1:0] ring_len,
  input logic             out_i,
  input logic             out_q,
  input logic             out_ix,
  input logic             out_qx,
  input logic             cfg_err
);

  logic [1:0] seen;
  logic       run_p;
  logic       run_r;

  // Rising edges observed since reset release, saturating.
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 2'd0;
    end else if (seen != 2'd3) begin
      seen <= seen + 2'd1;
    end
  end

  assign run_p = en && !ring_mode;
  assign run_r = en && ring_mode && !cfg_err;

  // R2: the in-phase output inverts on every enabled rising edge
  a_r2_pair_toggle: assert property (@(posedge clk2x) disable iff (!rst_n)
    (seen >= 2'd2 && !ring_mode && $past(run_p, 1) && $past(run_p, 2))
      |-> (out_i != $past(out_i)));

  // R3: after a falling edge the quadrature output matches the in-phase one
  a_r3_q_tracks_i: assert property (@(posedge clk2x) disable iff (!rst_n)
    (seen >= 2'd1 && !ring_mode && $past(run_p)) |-> (out_q == out_i));

  // R5: an edge pair with enable low leaves both phases low
  a_r5_disable_clears: assert property (@(posedge clk2x) disable iff (!rst_n)
    (seen >= 2'd1 && !$past(en)) |-> (!out_i && !out_q));

  // R7: ring outputs move one at a time
  a_r7_single_change: assert property (@(posedge clk2x) disable iff (!rst_n)
    (seen >= 2'd2 && ring_mode && !cfg_err && $past(run_r, 1) && $past(run_r, 2))
      |-> !((out_i != $past(out_i)) && (out_q != $past(out_q))));

  // R8: a refused ring length drives every phase low
  a_r8_err_quiet: assert property (@(posedge clk2x) disable iff (!rst_n)
    cfg_err |-> (!out_i && !out_q && !out_ix && !out_qx));

endmodule

bind qdiv_quad_gen qdiv_quad_gen_chk #(
  .MAX_STAGES (MAX_STAGES),
  .LEN_W      (LEN_W)
) u_chk (
  .clk2x     (clk2x),
  .rst_n     (rst_n),
  .en        (en),
  .ring_mode (ring_mode),
  .ring_len  (ring_len),
  .out_i     (out_i),
  .out_q     (out_q),
  .out_ix    (out_ix),
  .out_qx    (out_qx),
  .cfg_err   (cfg_err)
);

// File: tb/qdiv_quad_gen_tb.sv
module qdiv_quad_gen_tb;

  localparam int MAXS  = 8;
  localparam int LEN_W = 4;

  logic             clk2x = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b1;
  logic             ring_mode = 1'b0;
  logic [LEN_W-1:0] ring_len = '0;
  logic             out_i, out_q, out_ix, out_qx, cfg_err;

  int  n_vec = 0;
  int  n_bad = 0;
  int  r_pair = 0;
  int  r_ring = 0;
  bit  q_hold = 1'b0;
  bit  done = 1'b0;

  always #10 clk2x = ~clk2x;

  qdiv_quad_gen #(.MAX_STAGES(MAXS), .LEN_W(LEN_W)) u_dut (
    .clk2x(clk2x), .rst_n(rst_n), .en(en), .ring_mode(ring_mode),
    .ring_len(ring_len), .out_i(out_i), .out_q(out_q), .out_ix(out_ix),
    .out_qx(out_qx), .cfg_err(cfg_err)
  );

  function automatic bit len_ok(int m);
    return (m >= 2) && (m <= MAXS) && (m % 2 == 0);
  endfunction

  // Value of ring stage 0 after x enabled rising edges from clear.
  function automatic bit ring_lvl(int x, int m);
    if (x <= 0) return 1'b0;
    return ((x - 1) % (2 * m)) < m;
  endfunction

  // Expected {err,i,q,ix,qx}; qp is the pair core's Q level at this instant.
  function automatic logic [4:0] expect_vec(bit qp);
    bit e, i, q;
    int m;
    m = int'(ring_len);
    e = ring_mode && !len_ok(m);
    if (e) return 5'b10000;
    if (ring_mode) begin
      i = ring_lvl(r_ring, m);
      q = ring_lvl(r_ring - m / 2, m);
    end else begin
      i = (r_pair % 2) == 1;
      q = qp;
    end
    return {1'b0, i, q, ~i, ~q};
  endfunction

  task automatic compare(input logic [4:0] exp_v, input string tag);
    logic [4:0] got;
    got = {cfg_err, out_i, out_q, out_ix, out_qx};
    n_vec++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s t=%0t got %b exp %b (err,i,q,ix,qx)", tag, $time, got, exp_v);
    end
  endtask

  // Runs n input cycles; inputs stay fixed inside and may change on return.
  task automatic step(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      bit rp, rr;
      @(posedge clk2x);
      rp = en && !ring_mode;
      rr = en && ring_mode && len_ok(int'(ring_len));
      r_pair = rp ? r_pair + 1 : 0;
      r_ring = rr ? r_ring + 1 : 0;
      #5;
      compare(expect_vec(q_hold), tag);          // between rising and falling edge
      #10;
      q_hold = rp ? ((r_pair % 2) == 1) : 1'b0;  // Q copied I at the falling edge
      compare(expect_vec(q_hold), tag);
    end
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, exp finish within limit");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates even with enable high
    #25;
    compare(5'b00011, "R1 in reset");
    en = 1'b0;
    #20;
    rst_n = 1'b1;
    step(3, "R1 after release");

    // R2 R3 R4 R9: divide-by-two with an odd length that must be ignored
    ring_len = 4'd5;
    en = 1'b1;
    step(12, "R2 R3 R4 R9");
    ring_len = 4'd15;
    step(5, "R9 max length ignored");

    // R5: clear and restart
    en = 1'b0;
    step(3, "R5 disabled");
    en = 1'b1;
    step(8, "R5 R3 restart");

    // R6 R7 R8: sweep every length in ring arrangement
    ring_mode = 1'b1;
    for (int m = 0; m < 16; m++) begin
      ring_len = LEN_W'(m);
      if (len_ok(m)) step(4 * m + 2, "R6 R7 R4 ring");
      else           step(3, "R8 refused length");
    end

    // R10: switch arrangement while running
    ring_len = 4'd4;
    step(5, "R6 before switch");
    ring_mode = 1'b0;
    step(6, "R10 to pair");
    ring_mode = 1'b1;
    step(10, "R10 to ring");
    ring_len = 4'd7;
    step(2, "R8 mid run");
    ring_len = 4'd6;
    step(14, "R8 R6 ring restart");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule